// File: doc/BRIEF.md
# Error-Rate Driven Supply Voltage Controller

This block closes a digital loop around a supply regulator. It counts timing-error events reported by the processor's error-detecting flops over a programmable sampling window. When a window closes, it latches the count as the window's sample and subtracts that sample from a programmable target error rate. The signed difference, scaled down by a programmable right shift, then moves a 12-bit DAC code that sets the regulator's target voltage.

The loop does not try to reach zero errors. It holds a small, nonzero error rate on purpose, so the supply settles below the point where errors first appear. If errors are fewer than the target, the code falls and the supply drops. If there are more errors than the target, the code rises. The code is held between configured limits and never wraps. Reset puts the code at a safe high-voltage setting.

Window length and target rate are inputs, so software or a higher-level governor can retune the loop while it runs. The regulator, the DAC and the processor are outside the block.

Top module: `err_volt_ctrl`

## Requirements
- R1: While rst_ni is low, and after release until the first code update, dac_code_o equals RESET_CODE (default 3584).
- R2: A window lasts win_len_i clock cycles, and a value of 0 is treated as 1. dac_code_o changes at most once per window. A new code appears at the second rising edge after the window's last cycle: one edge latches the sample and the next edge updates the code.
- R3: A window's error count is the number of cycles inside that window in which err_i was high, including the window's last cycle. The count saturates at 2^CNT_W-1 (default 255).
- R4: The count restarts at zero for each window, so no events carry over from one window to the next.
- R5: On an update, new code = old code - ((ref_rate_i - count) arithmetically shifted right by step_shift_i). The shift floors toward minus infinity. A positive difference therefore lowers the code, and a negative difference raises it by at least 1.
- R6: When count equals ref_rate_i, dac_code_o is left unchanged.
- R7: dac_code_o never exceeds CODE_MAX (default 4000). A step that would pass it gives exactly CODE_MAX.
- R8: dac_code_o never falls below CODE_MIN (default 512). A step that would pass it gives exactly CODE_MIN.
- R9: If win_len_i is lowered to or below the number of cycles already elapsed in the current window, that window closes at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 1 | Timing-error event. Each cycle it is high counts as one event |
| ref_rate_i | input | CNT_W (8) | Target error count per window |
| win_len_i | input | WIN_W (16) | Window length in cycles. 0 acts as 1 |
| step_shift_i | input | SHIFT_W (3) | Right shift applied to the difference |
| dac_code_o | output | CODE_W (12) | Code sent to the regulator DAC |

## Verification
The DAC code is the only output, so every internal fault has to show up there. A timer that runs off count moves the code update to the wrong cycle, and the error is visible at the first window boundary. A count that is wrong, missing an event or carrying stale events gives a wrong step size one cycle after the window closes. A wrong sign, shift or clamp shows up as a wrong value at the same point. Because the reference model is compared on every clock, a mismatch is caught within one window plus two cycles of the fault.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned EVC_CODE_W  = 12;
  localparam int unsigned EVC_CNT_W   = 8;
  localparam int unsigned EVC_WIN_W   = 16;
  localparam int unsigned EVC_SHIFT_W = 3;
  localparam int unsigned EVC_CODE_MIN   = 512;
  localparam int unsigned EVC_CODE_MAX   = 4000;
  localparam int unsigned EVC_RESET_CODE = 3584;

  function automatic int unsigned evc_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/evc_window_timer.sv
module evc_window_timer #(
  parameter int unsigned WIN_W = evc_pkg::EVC_WIN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             tick_o
);
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] last_idx;

  // length 0 behaves as 1
  assign last_idx = (win_len_i == '0) ? '0 : win_len_i - WIN_W'(1);
  // >= so a shrunken window closes at once
  assign tick_o   = (cnt_q >= last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + WIN_W'(1);
  end

  AST_TICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0)); // R2
  AST_TIMER_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> (cnt_q == $past(cnt_q) + WIN_W'(1))); // R9
endmodule

// File: rtl/evc_err_counter.sv
module evc_err_counter #(
  parameter int unsigned CNT_W = evc_pkg::EVC_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] sample_o,
  output logic             sample_vld_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_inc;

  // saturating; includes the event of the current cycle
  assign acc_inc = (err_i && (acc_q != CNT_TOP)) ? acc_q + CNT_W'(1) : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= '0;
      sample_o     <= '0;
      sample_vld_o <= 1'b0;
    end else begin
      sample_vld_o <= tick_i;
      if (tick_i) begin
        sample_o <= acc_inc;
        acc_q    <= '0;
      end else begin
        acc_q    <= acc_inc;
      end
    end
  end

  AST_ACC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (acc_q == '0)); // R4
  AST_ACC_MONOTONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (acc_q >= $past(acc_q))); // R3
  AST_SAMPLE_FOLLOWS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> sample_vld_o); // R2
  AST_SAMPLE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sample_o)); // R2
endmodule

// File: rtl/evc_code_step.sv
module evc_code_step #(
  parameter int unsigned CODE_W     = evc_pkg::EVC_CODE_W,
  parameter int unsigned CNT_W      = evc_pkg::EVC_CNT_W,
  parameter int unsigned SHIFT_W    = evc_pkg::EVC_SHIFT_W,
  parameter int unsigned CODE_MIN   = evc_pkg::EVC_CODE_MIN,
  parameter int unsigned CODE_MAX   = evc_pkg::EVC_CODE_MAX,
  parameter int unsigned RESET_CODE = evc_pkg::EVC_RESET_CODE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic [CNT_W-1:0]   sample_i,
  input  logic [CNT_W-1:0]   ref_rate_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [CODE_W-1:0]  code_o
);
  localparam int unsigned DW = CNT_W + 1;
  localparam int unsigned SW = evc_pkg::evc_max(CODE_W, CNT_W) + 2;
  localparam logic signed [SW-1:0] LIM_HI = SW'(CODE_MAX);
  localparam logic signed [SW-1:0] LIM_LO = SW'(CODE_MIN);

  logic [CODE_W-1:0]        code_q;
  logic signed [DW-1:0]     diff;
  logic signed [DW-1:0]     step;
  logic signed [SW-1:0]     step_x;
  logic signed [SW-1:0]     code_x;
  logic signed [SW-1:0]     cand;
  logic [CODE_W-1:0]        code_nxt;

  assign diff   = $signed({1'b0, ref_rate_i}) - $signed({1'b0, sample_i});
  assign step   = diff >>> shift_i;
  assign step_x = $signed({{(SW-DW){step[DW-1]}}, step});
  assign code_x = $signed({{(SW-CODE_W){1'b0}}, code_q});
  assign cand   = code_x - step_x;

  always_comb begin
    if (cand > LIM_HI)      code_nxt = CODE_W'(CODE_MAX);
    else if (cand < LIM_LO) code_nxt = CODE_W'(CODE_MIN);
    else                    code_nxt = cand[CODE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    code_q <= CODE_W'(RESET_CODE);
    else if (upd_i) code_q <= code_nxt;
  end

  assign code_o = code_q;

  AST_CODE_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= CODE_W'(CODE_MAX)); // R7
  AST_CODE_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q >= CODE_W'(CODE_MIN)); // R8
  AST_CODE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(code_q)); // R2
  AST_LOWER_ON_SLACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && diff > 0) |=> (code_q <= $past(code_q))); // R5
  AST_RAISE_ON_EXCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && diff < 0) |=> (code_q >= $past(code_q))); // R5
  AST_HOLD_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && diff == 0) |=> $stable(code_q)); // R6
endmodule

// File: rtl/err_volt_ctrl.sv
module err_volt_ctrl #(
  parameter int unsigned CODE_W     = evc_pkg::EVC_CODE_W,
  parameter int unsigned CNT_W      = evc_pkg::EVC_CNT_W,
  parameter int unsigned WIN_W      = evc_pkg::EVC_WIN_W,
  parameter int unsigned SHIFT_W    = evc_pkg::EVC_SHIFT_W,
  parameter int unsigned CODE_MIN   = evc_pkg::EVC_CODE_MIN,
  parameter int unsigned CODE_MAX   = evc_pkg::EVC_CODE_MAX,
  parameter int unsigned RESET_CODE = evc_pkg::EVC_RESET_CODE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               err_i,
  input  logic [CNT_W-1:0]   ref_rate_i,
  input  logic [WIN_W-1:0]   win_len_i,
  input  logic [SHIFT_W-1:0] step_shift_i,
  output logic [CODE_W-1:0]  dac_code_o
);
  logic             tick;
  logic [CNT_W-1:0] sample;
  logic             sample_vld;

  evc_window_timer #(.WIN_W(WIN_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .win_len_i(win_len_i),
    .tick_o   (tick)
  );

  evc_err_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_i       (err_i),
    .tick_i      (tick),
    .sample_o    (sample),
    .sample_vld_o(sample_vld)
  );

  evc_code_step #(
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W),
    .SHIFT_W   (SHIFT_W),
    .CODE_MIN  (CODE_MIN),
    .CODE_MAX  (CODE_MAX),
    .RESET_CODE(RESET_CODE)
  ) i_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (sample_vld),
    .sample_i  (sample),
    .ref_rate_i(ref_rate_i),
    .shift_i   (step_shift_i),
    .code_o    (dac_code_o)
  );

  AST_RESET_CODE: assert property (@(posedge clk_i)
    !rst_ni |=> (rst_ni || dac_code_o == CODE_W'(RESET_CODE))); // R1
endmodule

// File: tb/test_err_volt_ctrl.sv
module test_err_volt_ctrl;
  localparam int CODE_W = 12, CNT_W = 8, WIN_W = 16, SHIFT_W = 3;
  localparam int CMIN = 512, CMAX = 4000, CRST = 3584;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               err = 1'b0;
  logic [CNT_W-1:0]   ref_rate = '0;
  logic [WIN_W-1:0]   win_len = 16'd8;
  logic [SHIFT_W-1:0] shift = '0;
  logic [CODE_W-1:0]  code;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  err_volt_ctrl i_err_volt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .ref_rate_i(ref_rate),
    .win_len_i(win_len), .step_shift_i(step_shift_wire()), .dac_code_o(code)
  );

  function automatic logic [SHIFT_W-1:0] step_shift_wire();
    return shift;
  endfunction

  // behavioural reference model
  int m_tcnt, m_acc, m_sample, m_code;
  bit m_vld;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tcnt = 0; m_acc = 0; m_sample = 0; m_vld = 0; m_code = CRST;
    end else begin
      int wl, last, inc, d, nc;
      bit tk;
      wl   = (win_len == 0) ? 1 : int'(win_len);
      last = wl - 1;
      if (m_vld) begin
        d  = int'(ref_rate) - m_sample;
        nc = m_code - (d >>> int'(shift));
        if (nc > CMAX) nc = CMAX;
        if (nc < CMIN) nc = CMIN;
        m_code = nc;
      end
      tk  = (m_tcnt >= last);
      inc = m_acc + (err ? 1 : 0);
      if (inc > 255) inc = 255;
      m_vld = tk;
      if (tk) begin m_sample = inc; m_acc = 0; m_tcnt = 0; end
      else begin m_acc = inc; m_tcnt = m_tcnt + 1; end
    end
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: dac_code_o actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pct: chance in percent of err high per cycle
  task automatic run(int n, int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(cur_req, int'(code), m_code);
      err = ($urandom_range(99) < pct);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(code), CRST);            // R1 during reset
    rst_n = 1'b1;
    win_len = 16'd8; ref_rate = 8'd4; shift = 3'd0; err = 1'b0;
    @(negedge clk);
    check("R1", int'(code), CRST);            // R1 after release
    cur_req = "R5"; run(200, 5);              // sparse errors: code lowers
    win_len = 16'd20; ref_rate = 8'd2; shift = 3'd2;
    cur_req = "R5"; run(400, 60);             // heavy errors: code raises
    win_len = 16'd50; ref_rate = 8'd0; shift = 3'd0;
    cur_req = "R7"; run(6000, 100);           // drive into ceiling
    check("R7", int'(code), CMAX);
    win_len = 16'd10; ref_rate = 8'd255;
    cur_req = "R8"; run(600, 0);              // drive into floor
    check("R8", int'(code), CMIN);
    win_len = 16'd16; ref_rate = 8'd8;
    cur_req = "R4";
    for (int k = 0; k < 20; k++) begin
      run(16, 100); run(16, 0);
    end
    win_len = 16'd20; ref_rate = 8'd10; shift = 3'd0;
    cur_req = "R6"; run(400, 50);             // around match
    win_len = 16'd400; ref_rate = 8'd255;
    cur_req = "R3"; run(2000, 100);           // saturates at 255 = ref
    win_len = 16'd300; ref_rate = 8'd200;
    cur_req = "R3"; run(1500, 100);           // saturated count raises code
    win_len = 16'd0; ref_rate = 8'd1; shift = 3'd1;
    cur_req = "R2"; run(300, 50);             // length 0 acts as 1
    win_len = 16'd1; shift = 3'd3;
    cur_req = "R2"; run(300, 50);
    for (int k = 0; k < 10; k++) begin
      win_len = 16'd100; ref_rate = 8'd3; shift = 3'(k % 4);
      cur_req = "R9"; run(30 + k, 20);
      win_len = 16'd10;                       // shrink below elapsed
      run(40, 20);
    end
    win_len = 16'd7; ref_rate = 8'd2; shift = 3'd1;
    cur_req = "R5"; run(1000, 30);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule